// File: doc/BRIEF.md
# Configuration Power-Up Sequencer

This block is the top-level phase controller of a field-programmable device. It steps the device from the moment power arrives to the point where user logic runs. First it waits out a power-on settling delay. Then it wipes the configuration store. Next it holds in an initialization phase for as long as the system reset request stays active. It then samples the mode-select pins once and waits in the loading phase until the bitstream loader reports completion. A start-up phase follows, and the block waits there until the start-up logic reports that it has finished. Only then does the device enter operational mode.

While the device is not yet operational, the block drives a pair of complementary configuration-busy pins. It holds the preparation status line low and enables weak pull-ups on the user I/O, which stay tristated. Once the device is operational, two paths lead away from that mode. A reprogram request returns the device to the memory wipe. A power-down request parks the device in a state that drives nothing, and the device resumes operation when the request is withdrawn.

The bitstream parsing and the configuration memory itself sit outside this block. The block sees them only through the `load_done` and `startup_done` flags.

Top module: `cfg_powerup_seq`

## Requirements
- R1: The `phase` output reports the state as follows: 0 = power-on delay, 1 = memory clear, 2 = initialization, 3 = mode test, 4 = loading, 5 = start-up, 6 = operational, 7 = power-down. From power-up the block visits these phases in the order 0,1,2,3,4,5,6. Phase 1 is entered only from phase 0, 2 or 6.
- R2: After `rst_n` is released, the block takes two clock edges to synchronize the reset. It then stays in phase 0 for exactly `POR_CYCLES` cycles before entering phase 1.
- R3: Phase 1 lasts exactly `CLEAR_CYCLES` cycles and is then followed by phase 2.
- R4: In phase 2, an active `reset_req` sends the block back to phase 1 on the next edge. The block does not advance to phase 3 while `reset_req` is active.
- R5: The `mode_pins` value is captured on the edge that moves the block from phase 2 to phase 3. `mode_q` then holds that value through phases 3 to 7, whatever `mode_pins` does.
- R6: In phases 1 to 4, `cfg_hi` is 1 and `cfg_lo` is 0. In phases 0, 5 and 6, `cfg_hi` is 0 and `cfg_lo` is 1. In phase 7, both pins and `cfg_pin_oe` are 0. In every other phase, `cfg_pin_oe` is 1.
- R7: In phases 0 to 5, `prep_n` is 0, `io_pullup_en` is 1 and `user_active` is 0. In phase 6, `prep_n` is 1, `io_pullup_en` is 0 and `user_active` is 1. In phase 7, `prep_n` is 1 and both `io_pullup_en` and `user_active` are 0.
- R8: In phase 6, if `done_pin_lvl` is 0 and `reset_req` is 1 while `pwr_down` is 0, the block enters phase 1 on the next edge. If `done_pin_lvl` is 1, the reset request has no effect.
- R9: In phase 6, `pwr_down` = 1 moves the block to phase 7 and takes priority over a reprogram. In phase 7, `pwr_down` = 0 returns the block to phase 6. In every phase other than 6 and 7, `pwr_down` has no effect.
- R10: Driving `rst_n` low forces phase 0 and clears `mode_q` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req | input | 1 | System reset request, active high |
| pwr_down | input | 1 | Power-down request, active high |
| done_pin_lvl | input | 1 | Sensed level of the done/program pin |
| mode_pins | input | MODE_W | Configuration mode-select pins |
| load_done | input | 1 | Bitstream loading complete |
| startup_done | input | 1 | Start-up sequence complete |
| phase | output | 3 | Current phase code (see R1) |
| cfg_hi | output | 1 | High-during-configuration pin value |
| cfg_lo | output | 1 | Low-during-configuration pin value |
| cfg_pin_oe | output | 1 | Drive enable of the two configuration pins |
| prep_n | output | 1 | Preparation status, low before operation |
| io_pullup_en | output | 1 | User I/O tristated with pull-up |
| user_active | output | 1 | User logic running |
| mode_q | output | MODE_W | Captured mode-select value |

## Verification
The bench builds the block with `POR_CYCLES` = 5, `CLEAR_CYCLES` = 3 and `MODE_W` = 3. With these values, both delay counters run to expiry within a few cycles, so the bench can count their exact lengths at the ports rather than only observing that they end. The short clear window also lets the bench loop the initialization-to-clear path several times and reprogram from operational mode, while still revisiting the mode capture after the loop. The 3-bit mode field is wide enough to show a captured value that differs from a later pin value.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    PH_POR     = 3'd0,
    PH_CLEAR   = 3'd1,
    PH_INIT    = 3'd2,
    PH_MODE    = 3'd3,
    PH_LOAD    = 3'd4,
    PH_STARTUP = 3'd5,
    PH_OPER    = 3'd6,
    PH_PWRDN   = 3'd7
  } cfg_phase_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  generate
    if (CYCLES <= 1) begin : g_single
      assign expire = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          at_last;

      assign at_last = (cnt_q == LAST);

      always_comb begin
        if (!run) begin
          cnt_d = '0;
        end else if (at_last) begin
          cnt_d = cnt_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign expire = run && at_last;
    end
  endgenerate

endmodule

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] pins,
  output logic [W-1:0] held
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (capture) begin
      held_q <= pins;
    end
  end

  assign held = held_q;

endmodule

// File: rtl/cfg_powerup_seq.sv
module cfg_powerup_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned POR_CYCLES   = 1000,
  parameter int unsigned CLEAR_CYCLES = 64,
  parameter int unsigned MODE_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              pwr_down,
  input  logic              done_pin_lvl,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              load_done,
  input  logic              startup_done,
  output logic [2:0]        phase,
  output logic              cfg_hi,
  output logic              cfg_lo,
  output logic              cfg_pin_oe,
  output logic              prep_n,
  output logic              io_pullup_en,
  output logic              user_active,
  output logic [MODE_W-1:0] mode_q
);

  localparam int unsigned SYNC_STAGES = 2;

  cfg_phase_e state_q;
  cfg_phase_e state_d;
  logic       rst_n_i;
  logic       por_expire;
  logic       clr_expire;
  logic       mode_cap;
  logic       in_cfg;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  cfg_cycle_timer #(.CYCLES(POR_CYCLES)) u_por_timer (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .run    (state_q == PH_POR),
    .expire (por_expire)
  );

  cfg_cycle_timer #(.CYCLES(CLEAR_CYCLES)) u_clr_timer (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .run    (state_q == PH_CLEAR),
    .expire (clr_expire)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_POR:     if (por_expire) state_d = PH_CLEAR;
      PH_CLEAR:   if (clr_expire) state_d = PH_INIT;
      PH_INIT:    state_d = reset_req ? PH_CLEAR : PH_MODE;
      PH_MODE:    state_d = PH_LOAD;
      PH_LOAD:    if (load_done) state_d = PH_STARTUP;
      PH_STARTUP: if (startup_done) state_d = PH_OPER;
      PH_OPER: begin
        if (pwr_down) begin
          state_d = PH_PWRDN;
        end else if (!done_pin_lvl && reset_req) begin
          state_d = PH_CLEAR;
        end
      end
      PH_PWRDN:   if (!pwr_down) state_d = PH_OPER;
      default:    state_d = PH_POR;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= PH_POR;
    end else begin
      state_q <= state_d;
    end
  end

  assign mode_cap = (state_q == PH_INIT) && (state_d == PH_MODE);

  cfg_mode_latch #(.W(MODE_W)) u_mode_latch (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .capture (mode_cap),
    .pins    (mode_pins),
    .held    (mode_q)
  );

  // Output decode
  assign in_cfg = (state_q == PH_CLEAR) || (state_q == PH_INIT) ||
                  (state_q == PH_MODE)  || (state_q == PH_LOAD);

  always_comb begin
    phase        = state_q;
    cfg_pin_oe   = (state_q != PH_PWRDN);
    cfg_hi       = in_cfg;
    cfg_lo       = !in_cfg && (state_q != PH_PWRDN);
    prep_n       = (state_q == PH_OPER) || (state_q == PH_PWRDN);
    io_pullup_en = !prep_n;
    user_active  = (state_q == PH_OPER);
  end

endmodule

// File: rtl/cfg_powerup_seq_chk.sv
module cfg_powerup_seq_chk #(
  parameter int unsigned MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reset_req,
  input logic              pwr_down,
  input logic              done_pin_lvl,
  input logic [2:0]        phase,
  input logic              cfg_hi,
  input logic              cfg_lo,
  input logic              cfg_pin_oe,
  input logic              prep_n,
  input logic              io_pullup_en,
  input logic [MODE_W-1:0] mode_q
);

  assert_clear_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |-> ($past(phase) inside {3'd0, 3'd1, 3'd2, 3'd6}));

  assert_cfg_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> (cfg_hi && !cfg_lo && cfg_pin_oe));

  assert_pwrdn_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |-> (!cfg_pin_oe && !cfg_hi && !cfg_lo && !io_pullup_en));

  assert_prep_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= 3'd5) |-> (!prep_n && io_pullup_en));

  assert_init_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 && reset_req) |=> (phase == 3'd1));

  assert_reprogram_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd6 && !pwr_down && !done_pin_lvl && reset_req) |=> (phase == 3'd1));

  assert_pwrdn_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd6 && pwr_down) |=> (phase == 3'd7));

  assert_mode_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {3'd4, 3'd5, 3'd6, 3'd7}) |-> $stable(mode_q));

endmodule

bind cfg_powerup_seq cfg_powerup_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reset_req    (reset_req),
  .pwr_down     (pwr_down),
  .done_pin_lvl (done_pin_lvl),
  .phase        (phase),
  .cfg_hi       (cfg_hi),
  .cfg_lo       (cfg_lo),
  .cfg_pin_oe   (cfg_pin_oe),
  .prep_n       (prep_n),
  .io_pullup_en (io_pullup_en),
  .mode_q       (mode_q)
);

// File: tb/cfg_powerup_seq_tb.sv
`timescale 1ns/1ps
module cfg_powerup_seq_tb;

  localparam int unsigned POR_C  = 5;
  localparam int unsigned CLR_C  = 3;
  localparam int unsigned MW     = 3;
  localparam int unsigned NSTEPS = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reset_req, pwr_down, done_pin_lvl, load_done, startup_done;
  logic [MW-1:0] mode_pins;
  logic [2:0]    phase;
  logic          cfg_hi, cfg_lo, cfg_pin_oe, prep_n, io_pullup_en, user_active;
  logic [MW-1:0] mode_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_powerup_seq #(.POR_CYCLES(POR_C), .CLEAR_CYCLES(CLR_C), .MODE_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .pwr_down(pwr_down),
    .done_pin_lvl(done_pin_lvl), .mode_pins(mode_pins), .load_done(load_done),
    .startup_done(startup_done), .phase(phase), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_pin_oe(cfg_pin_oe), .prep_n(prep_n), .io_pullup_en(io_pullup_en),
    .user_active(user_active), .mode_q(mode_q)
  );

  typedef struct packed {
    logic       rr;
    logic       pw;
    logic       dn;
    logic       ld;
    logic       sd;
    logic [2:0] md;
    logic [3:0] cyc;
    logic [2:0] ph;
    logic       cm;
    logic [2:0] em;
  } vec_t;

  localparam vec_t VEC [NSTEPS] = '{
    '{1'b1,1'b0,1'b1,1'b0,1'b0,3'd0,4'd1,3'd1,1'b0,3'd0}, // R4 init with reset -> clear
    '{1'b1,1'b0,1'b1,1'b0,1'b0,3'd0,4'd3,3'd2,1'b0,3'd0}, // R3 clear length
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd5,4'd1,3'd3,1'b1,3'd5}, // R5 capture
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,4'd1,3'd4,1'b1,3'd5}, // R5 held
    '{1'b0,1'b1,1'b1,1'b0,1'b0,3'd2,4'd3,3'd4,1'b1,3'd5}, // R9 ignored while loading
    '{1'b0,1'b0,1'b1,1'b1,1'b0,3'd2,4'd1,3'd5,1'b0,3'd0}, // R1 to start-up
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,4'd2,3'd5,1'b1,3'd5}, // R1 wait start-up
    '{1'b0,1'b0,1'b1,1'b0,1'b1,3'd2,4'd1,3'd6,1'b0,3'd0}, // R1 to operational
    '{1'b1,1'b0,1'b1,1'b0,1'b0,3'd2,4'd2,3'd6,1'b0,3'd0}, // R8 done high blocks
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,4'd2,3'd6,1'b0,3'd0}, // R8 no reset request
    '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd2,4'd1,3'd7,1'b0,3'd0}, // R9 priority
    '{1'b0,1'b1,1'b0,1'b0,1'b0,3'd2,4'd3,3'd7,1'b1,3'd5}, // R9 stays down
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,4'd1,3'd6,1'b0,3'd0}, // R9 resume
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,4'd1,3'd1,1'b0,3'd0}, // R8 reprogram
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd6,4'd3,3'd2,1'b0,3'd0}, // R3 clear again
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd6,4'd1,3'd3,1'b1,3'd6}  // R5 new capture
  };

  function automatic string step_tag(int i);
    case (i)
      0:              return "R4";
      1, 14:          return "R3";
      2, 3, 15:       return "R5";
      4, 10, 11, 12:  return "R9";
      8, 9, 13:       return "R8";
      default:        return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected pin group per phase, packed as {hi, lo, oe} and {prep_n, pullup, user}
  function automatic logic [2:0] exp_pins(logic [2:0] ph);
    if (ph == 3'd7) return 3'b000;
    if (ph >= 3'd1 && ph <= 3'd4) return 3'b101;
    return 3'b011;
  endfunction

  function automatic logic [2:0] exp_stat(logic [2:0] ph);
    if (ph <= 3'd5) return 3'b010;
    if (ph == 3'd6) return 3'b101;
    return 3'b100;
  endfunction

  task automatic check_outputs(logic [2:0] ph);
    check("R6 pins", {cfg_hi, cfg_lo, cfg_pin_oe}, exp_pins(ph));
    check("R7 status", {prep_n, io_pullup_en, user_active}, exp_stat(ph));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; reset_req = 1'b1; pwr_down = 1'b0; done_pin_lvl = 1'b1;
    load_done = 1'b0; startup_done = 1'b0; mode_pins = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset phase", phase, 3'd0);
    check("R10 reset mode", mode_q, '0);
    check_outputs(3'd0);

    // R2: power-on delay length after reset release
    rst_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (phase == 3'd0 && n < 100);
    check("R2 por length", n, POR_C + 2);
    check("R1 after por", phase, 3'd1);

    // R3: clear length
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (phase == 3'd1 && n < 100);
    check("R3 clear length", n, CLR_C);
    check("R3 after clear", phase, 3'd2);

    // Table walk starting in initialization
    for (int i = 0; i < NSTEPS; i++) begin
      reset_req    = VEC[i].rr;
      pwr_down     = VEC[i].pw;
      done_pin_lvl = VEC[i].dn;
      load_done    = VEC[i].ld;
      startup_done = VEC[i].sd;
      mode_pins    = VEC[i].md;
      repeat (int'(VEC[i].cyc)) @(posedge clk);
      @(negedge clk);
      check(step_tag(i), phase, VEC[i].ph);
      check_outputs(VEC[i].ph);
      if (VEC[i].cm) check("R5 mode", mode_q, VEC[i].em);
    end

    // R10: asynchronous reset mid-run, observed before any edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async phase", phase, 3'd0);
    check("R10 async mode", mode_q, '0);
    check_outputs(3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    reset_req = 1'b0;

    // R4 negative: without reset request init advances directly
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (phase != 3'd2 && n < 100);
    check("R2 R3 second power-up", n, POR_C + 2 + CLR_C);
    @(posedge clk); @(negedge clk);
    check("R4 no reset advances", phase, 3'd3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule